// File: doc/BRIEF.md
# Synchronous Serial I/O Port

This block is an 8-bit synchronous serial port with a clock pin, a serial data output and a serial data input. Software reaches it through a small register bus: a control register (port enable, master select), a status register (transfer-complete flag, write-collision flag) and a data register. In master mode a write to the data register starts a byte transfer, and the block drives the serial clock at one quarter of the system clock. In slave mode the same write arms the shifter, which then moves one bit per edge of an externally supplied clock. The data lines behave the same in both modes. Only the direction of the clock pin follows the mode.

Data moves MSB first. The output bit changes on the falling clock edge and the input bit is sampled on the rising edge. The clock idles high. The transfer-complete flag sets on the eighth rising edge. Clearing the enable bit or the master bit mid-byte abandons the transfer. The partial byte is dropped, the bit counter returns to zero and the data register keeps its earlier value. While the port is disabled the pins are handed back to general-purpose use.

The controller has three states. `ST_IDLE` leaves it through start: to `ST_MASTER` when master select is set, otherwise to `ST_SLAVE`. Each run state returns to `ST_IDLE` through either finish (the eighth rising edge) or abort (the mode bits no longer match the running state). When both apply in one cycle, abort wins.

Top module: `sio_port`

## Requirements
- R1: After reset the control register (offset 0x0A) and the status register (offset 0x0B) read 0, sck_out is high, sck_oe is 0 and pins_serial is 0.
- R2: With control = 0x03 (bit 0 enable, bit 1 master), a data-register write (offset 0x0C) starts a transfer. sck_oe is 1, and sck_out is low for 2 clocks then high for 2 clocks, for 8 periods, then idles high.
- R3: sdo presents the written byte MSB first and changes only at falling clock edges. sdi is sampled at each rising edge. After the transfer the data register reads the 8 sampled bits, first bit in bit 7.
- R4: Status bit 7 (transfer complete) sets on the eighth rising edge. In master mode that is the 30th clock after the write edge.
- R5: A data write during a transfer sets status bit 6 (collision) and is otherwise ignored: the running transfer and its received byte are unaffected.
- R6: Both flags clear only on a data-register access that follows a status read. A data read without a preceding status read leaves them set.
- R7: Clearing the enable bit aborts a transfer. No flag sets, the data register keeps its old value, pins_serial drops, and the next transfer again needs a full 8 bits.
- R8: Clearing the master bit during a master transfer aborts it, with no flag and the data register unchanged.
- R9: The master bit can be written and read back while the port is disabled.
- R10: With control = 0x01 (slave), the port never drives the clock (sck_oe 0, sck_out high). It shifts on sck_in edges and sets the flag after 8 rising edges.
- R11: A data write while the port is disabled starts nothing: sck_out stays high and no flag sets.
- R12: Slave clock edges do not advance the bit count while the port is disabled, so a transfer armed after re-enabling needs all 8 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Clock pin drive enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| pins_serial | output | 1 | 1 = pins serve the port, 0 = general-purpose I/O |

## Verification
Control writes take effect one clock after their bus edge. In master mode the clock pattern is fixed: the output level in cycle k after the write edge is high exactly when k mod 4 is 2 or 3, and the completion flag is present from cycle 30. The bench therefore steps on falling clock edges, counts k from the write, and checks sck, sdo and the flag against that count. Slave edges pass through a two-stage synchronizer and show up 2 to 3 clocks late, so the bench holds each slave clock half for 4 clocks and samples only at the end of each half.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MASTER,
        ST_SLAVE
    } sio_state_e;

    localparam int ADDR_CTRL = 'hA;
    localparam int ADDR_STAT = 'hB;
    localparam int ADDR_DATA = 'hC;
endpackage

// File: rtl/sio_sck_sync.sv
module sio_sck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-1:0], sck_in};
    end

    assign sck_rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign sck_fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];

    assert_edges_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_rise && sck_fall));
endmodule

// File: rtl/sio_regs.sv
module sio_regs
    import sio_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    ctrl_wdata,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] rx_byte,
    output logic          en,
    output logic          mst,
    output logic          start,
    output logic [DW-1:0] bus_rdata
);
    logic          armed_q, spif_q, dcol_q;
    logic [DW-1:0] data_q;
    logic          wr_ctrl, rd_stat, acc_data, wr_data, collide;

    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == AW'(ADDR_CTRL));
    assign rd_stat  = bus_sel && !bus_wr && (bus_addr == AW'(ADDR_STAT));
    assign acc_data = bus_sel && (bus_addr == AW'(ADDR_DATA));
    assign wr_data  = acc_data && bus_wr;
    assign start    = wr_data && en && !busy;
    assign collide  = wr_data && en && busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b0;
            mst     <= 1'b0;
            armed_q <= 1'b0;
            spif_q  <= 1'b0;
            dcol_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en  <= ctrl_wdata[0];
                mst <= ctrl_wdata[1];
            end
            if (rd_stat && (spif_q || dcol_q)) armed_q <= 1'b1;
            else if (acc_data)                 armed_q <= 1'b0;
            if (done)                       spif_q <= 1'b1;
            else if (acc_data && armed_q)   spif_q <= 1'b0;
            if (collide)                    dcol_q <= 1'b1;
            else if (acc_data && armed_q)   dcol_q <= 1'b0;
            if (done) data_q <= rx_byte;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_CTRL))      bus_rdata = DW'({mst, en});
        else if (bus_addr == AW'(ADDR_STAT)) bus_rdata = {spif_q, dcol_q, {(DW-2){1'b0}}};
        else if (bus_addr == AW'(ADDR_DATA)) bus_rdata = data_q;
    end

    assert_flag_from_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spif_q) |-> $past(done));
    assert_collision_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dcol_q) |-> $past(busy));
    assert_data_kept_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(data_q));
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    input  logic          sdi,
    output logic          sdo,
    output logic          pins_serial
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int CW = $clog2(DW);

    sio_state_e    state_q, state_d;
    logic [PW-1:0] ph_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] shift_q, rx_byte;
    logic          sdo_q;
    logic          en, mst, start, busy, done;
    logic          s_rise, s_fall, rise_evt, fall_evt, last, abort;

    sio_regs #(.DW(DW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .ctrl_wdata(bus_wdata[1:0]), .busy(busy),
        .done(done), .rx_byte(rx_byte), .en(en), .mst(mst), .start(start),
        .bus_rdata(bus_rdata)
    );

    sio_sck_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in),
        .sck_rise(s_rise), .sck_fall(s_fall)
    );

    assign rise_evt = (state_q == ST_MASTER && ph_q == PW'(DIV/2 - 1)) ||
                      (state_q == ST_SLAVE && s_rise);
    assign fall_evt = (state_q == ST_MASTER && ph_q == PW'(DIV - 1)) ||
                      (state_q == ST_SLAVE && s_fall);
    assign last     = rise_evt && (cnt_q == CW'(DW - 1));
    assign abort    = (state_q == ST_MASTER && !(en && mst)) ||
                      (state_q == ST_SLAVE && !(en && !mst));
    assign done     = last && !abort;
    assign rx_byte  = {shift_q[DW-2:0], sdi};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = mst ? ST_MASTER : ST_SLAVE;
            ST_MASTER,
            ST_SLAVE:  if (abort || last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= '0;
            cnt_q   <= '0;
            shift_q <= '0;
            sdo_q   <= 1'b0;
        end else if (start) begin
            ph_q    <= '0;
            cnt_q   <= '0;
            shift_q <= bus_wdata;
            sdo_q   <= bus_wdata[DW-1];
        end else if (abort) begin
            ph_q  <= '0;
            cnt_q <= '0;
        end else if (state_q != ST_IDLE) begin
            if (state_q == ST_MASTER)
                ph_q <= (ph_q == PW'(DIV - 1)) ? '0 : ph_q + 1'b1;
            if (rise_evt) begin
                shift_q <= rx_byte;
                cnt_q   <= cnt_q + 1'b1;
            end
            if (fall_evt) sdo_q <= shift_q[DW-1];
        end
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        sck_out     = !(state_q == ST_MASTER && ph_q < PW'(DIV/2));
        sck_oe      = en && mst;
        pins_serial = en;
        sdo         = sdo_q;
    end

    assert_disable_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    assert_master_clear_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MASTER && !mst) |=> (state_q == ST_IDLE));
    assert_slave_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |-> sck_out);
    assert_sdo_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MASTER && $past(state_q == ST_MASTER) && sck_out && $past(sck_out))
        |-> $stable(sdo_q));
endmodule

// File: tb/sio_port_tb_top.sv
module sio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck_in = 1'b1, sdi = 1'b0;
    logic       sck_out, sck_oe, sdo, pins_serial;
    int         total = 0, bad = 0;
    bit         finished = 0;

    localparam logic [3:0] A_CTRL = 4'hA, A_STAT = 4'hB, A_DATA = 4'hC;

    always #2.5 clk = ~clk;

    sio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi),
        .sdo(sdo), .pins_serial(pins_serial)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        bus_read(a, v);
        check(v == e, req, v, e);
    endtask

    task automatic hold_idle(input int n, input string req);
        int errs = 0;
        for (int i = 0; i < n; i++) begin
            if (sck_out !== 1'b1) errs++;
            @(negedge clk);
        end
        check(errs == 0, req, errs, 0);
    endtask

    // Master byte with full waveform and timing checks (R2, R3, R4)
    task automatic run_master(input logic [7:0] tx, input logic [7:0] rx);
        int sck_err = 0, sdo_err = 0;
        bus_write(A_DATA, tx);
        check(sck_oe === 1'b1, "R2 sck_oe", sck_oe, 1);
        for (int k = 0; k < 30; k++) begin
            if (k % 4 == 0) sdi = rx[7 - k/4];
            if (sck_out !== ((k % 4) >= 2)) sck_err++;
            if (sdo !== tx[7 - k/4]) sdo_err++;
            @(negedge clk);
        end
        check(sck_err == 0, "R2 sck pattern", sck_err, 0);
        check(sdo_err == 0, "R3 sdo msb first", sdo_err, 0);
        check(sck_out === 1'b1, "R2 idle high", sck_out, 1);
        expect_reg(A_STAT, 8'h80, "R4 flag at cycle 30");
        expect_reg(A_DATA, rx, "R3 received byte");
        expect_reg(A_STAT, 8'h00, "R6 flags cleared");
    endtask

    task automatic slave_pulse(input logic b);
        sck_in = 1'b0; sdi = b;
        repeat (4) @(negedge clk);
        sck_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check(sck_out === 1'b1 && sck_oe === 1'b0 && pins_serial === 1'b0,
              "R1 pins", {sck_out, sck_oe, pins_serial}, 3'b100);
        expect_reg(A_CTRL, 8'h00, "R1 ctrl");
        expect_reg(A_STAT, 8'h00, "R1 status");
    endtask

    task automatic t_mode_bits();
        bus_write(A_CTRL, 8'h02);
        expect_reg(A_CTRL, 8'h02, "R9 master bit readback");
        check(sck_oe === 1'b0 && pins_serial === 1'b0, "R9 still disabled",
              {sck_oe, pins_serial}, 0);
    endtask

    task automatic t_write_disabled();
        bus_write(A_DATA, 8'h3C);
        hold_idle(40, "R11 no clock when disabled");
        expect_reg(A_STAT, 8'h00, "R11 no flag");
        expect_reg(A_DATA, 8'h00, "R11 data unchanged");
    endtask

    task automatic t_master();
        bus_write(A_CTRL, 8'h03);
        check(pins_serial === 1'b1, "R2 pins serial", pins_serial, 1);
        run_master(8'hA5, 8'h5C);
        run_master(8'h0F, 8'hF0);
    endtask

    task automatic t_flag_clear_order();
        logic [7:0] v;
        bus_write(A_DATA, 8'h11);
        sdi = 1'b0;
        repeat (30) @(negedge clk);
        bus_read(A_DATA, v);
        expect_reg(A_STAT, 8'h80, "R6 data read alone keeps flag");
        bus_read(A_DATA, v);
        expect_reg(A_STAT, 8'h00, "R6 status then data clears");
    endtask

    task automatic t_collision();
        bus_write(A_DATA, 8'h81);
        sdi = 1'b1;
        repeat (6) @(negedge clk);
        bus_write(A_DATA, 8'h00);
        repeat (23) @(negedge clk);
        expect_reg(A_STAT, 8'hC0, "R5 collision and complete");
        expect_reg(A_DATA, 8'hFF, "R5 transfer unaffected");
        expect_reg(A_STAT, 8'h00, "R5 flags cleared");
    endtask

    task automatic t_abort_enable();
        bus_write(A_DATA, 8'h12);
        sdi = 1'b0;
        repeat (10) @(negedge clk);
        bus_write(A_CTRL, 8'h02);
        check(pins_serial === 1'b0, "R7 pins released", pins_serial, 0);
        hold_idle(40, "R7 clock stopped");
        expect_reg(A_STAT, 8'h00, "R7 no flag");
        expect_reg(A_DATA, 8'hFF, "R7 data kept");
        bus_write(A_CTRL, 8'h03);
        run_master(8'h66, 8'h99);
    endtask

    task automatic t_abort_master();
        bus_write(A_DATA, 8'h34);
        repeat (10) @(negedge clk);
        bus_write(A_CTRL, 8'h01);
        hold_idle(40, "R8 clock stopped");
        expect_reg(A_STAT, 8'h00, "R8 no flag");
        expect_reg(A_DATA, 8'h99, "R8 data kept");
    endtask

    task automatic t_slave();
        logic [7:0] tx = 8'hC3, rx = 8'h2D;
        int sdo_err = 0, drv_err = 0;
        bus_write(A_CTRL, 8'h01);
        bus_write(A_DATA, tx);
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0; sdi = rx[7 - i];
            repeat (4) @(negedge clk);
            if (sdo !== tx[7 - i]) sdo_err++;
            if (sck_oe !== 1'b0 || sck_out !== 1'b1) drv_err++;
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(sdo_err == 0, "R10 slave sdo", sdo_err, 0);
        check(drv_err == 0, "R10 slave no drive", drv_err, 0);
        expect_reg(A_STAT, 8'h80, "R10 slave flag");
        expect_reg(A_DATA, rx, "R10 slave received");
        expect_reg(A_STAT, 8'h00, "R10 flags cleared");
    endtask

    task automatic t_slave_disabled();
        bus_write(A_DATA, 8'h00);
        for (int i = 0; i < 3; i++) slave_pulse(1'b0);
        bus_write(A_CTRL, 8'h00);
        for (int i = 0; i < 3; i++) slave_pulse(1'b0);
        bus_write(A_CTRL, 8'h01);
        bus_write(A_DATA, 8'hFF);
        for (int i = 0; i < 7; i++) slave_pulse(1'b1);
        repeat (4) @(negedge clk);
        expect_reg(A_STAT, 8'h00, "R12 seven edges not enough");
        slave_pulse(1'b1);
        repeat (4) @(negedge clk);
        expect_reg(A_STAT, 8'h80, "R12 eighth edge completes");
        expect_reg(A_DATA, 8'hFF, "R12 full byte");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_bits();
        t_write_disabled();
        t_master();
        t_flag_clear_order();
        t_collision();
        t_abort_enable();
        t_abort_master();
        t_slave();
        t_slave_disabled();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule